// File: doc/BRIEF.md
# Two-Wire Serial Memory Target

This block is the target end of a two-wire serial memory link. It runs on a fast system clock. The clock and data wires are oversampled through a short synchroniser, and edges are found on the synchronised copies. The block never drives the data wire high. It only asserts an open-drain pull-down enable, and the pad outside turns that enable into a low level.

A transfer begins when the data wire falls while the clock wire is high, and it finishes when the data wire rises while the clock is high. The first byte holds a fixed 4-bit type code (1010), three select bits and a direction bit. A matching write goes on to carry a word address and then any number of data bytes, which collect in a one-page buffer. A matching read streams bytes out of a 256-byte array. Buffered data is copied into the array when the closing stop arrives. A programming interval follows, and while it runs the target answers nothing on the bus.

Top module: `i2c_eep_slave`

## Requirements
- R1: A falling data wire while the synchronised clock is high (a start) always restarts reception of a device byte. This holds in every state, so a repeated start is accepted too.
- R2: A rising data wire while the clock is high (a stop) ends the transfer and releases the data wire.
- R3: Incoming bits are sampled on clock rising edges, most significant bit first. The pull-down enable changes only while the clock is low.
- R4: A device byte of the form 1010, ADDR_SEL[2:0], direction (bit 0: 1 = read, 0 = write) is acknowledged by pulling data low for the whole ninth clock. Any other device byte gets no acknowledge, and the target stays silent until the next start or stop.
- R5: After the device byte of a write, the next byte sets the word address. Each following data byte is acknowledged and buffered at the page of that address. The low 4 bits of the address step by one per byte.
- R6: When more than 16 data bytes arrive, the offset wraps within the 16-byte page. Later bytes overwrite earlier ones, only the last sixteen are kept, and no byte lands outside the page.
- R7: A stop that ends a write carrying at least one data byte commits the buffered bytes. It also starts a busy interval of PROG_CYCLES system clocks. A write that has only a word address and no data starts no busy interval.
- R8: During the busy interval no acknowledge is given, not even to a matching device byte.
- R9: A read sends the byte at the current word address, most significant bit first. After each byte the address goes up by one and wraps from 255 to 0.
- R10: When the master does not acknowledge a read byte, the target releases the data wire and drives nothing more until the next start or stop.
- R11: After reset the data wire is released, the word address is 0 and every array byte reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than the bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock wire level |
| sda_i | input | 1 | Bus data wire level (wired-AND of all drivers) |
| sda_oe_o | output | 1 | 1 = pull the data wire low |

## Verification
The hardest behaviour to reach from the ports is the page overflow. The test needs a write long enough to wrap the offset past its starting point and overwrite earlier bytes. It must then wait out the busy interval and read back the whole page plus the first byte of the next page. The bench writes twenty bytes from a mid-page offset and computes, for each offset, which of the twenty bytes should be the survivor. The busy interval is hit the same way: the bench tries to address the target straight after a committing stop and expects no acknowledge. All 128 device addresses are also swept, to confirm that only one address is answered.

// File: rtl/i2c_eep_pkg.sv
package i2c_eep_pkg;
  localparam logic [3:0] DEV_TYPE = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_WADDR,
    ST_WDATA,
    ST_ACK,
    ST_TX,
    ST_RACK,
    ST_SKIP
  } eep_state_e;
endpackage

// File: rtl/i2c_eep_sync.sv
module i2c_eep_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic              scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_ff[STAGES-1];
      sda_q  <= sda_ff[STAGES-1];
    end
  end

  assign scl_o      = scl_ff[STAGES-1];
  assign sda_o      = sda_ff[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_q;
  assign scl_fall_o = ~scl_o & scl_q;
  assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/i2c_eep_store.sv
module i2c_eep_store #(
  parameter int MEM_AW  = 8,
  parameter int PAGE_AW = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MEM_AW-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o,
  input  logic              clear_i,
  input  logic              wr_en_i,
  input  logic [MEM_AW-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic              commit_i,
  output logic              pending_o
);
  localparam int MEM_DEPTH  = 1 << MEM_AW;
  localparam int PAGE_DEPTH = 1 << PAGE_AW;
  localparam int PG_W       = MEM_AW - PAGE_AW;

  logic [7:0]            mem_q  [MEM_DEPTH];
  logic [7:0]            pbuf_q [PAGE_DEPTH];
  logic [PAGE_DEPTH-1:0] mask_q;
  logic [PG_W-1:0]       page_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < MEM_DEPTH; i++) mem_q[i] <= '0;
    end else if (commit_i) begin
      for (int i = 0; i < PAGE_DEPTH; i++)
        if (mask_q[i]) mem_q[{page_q, PAGE_AW'(i)}] <= pbuf_q[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < PAGE_DEPTH; i++) pbuf_q[i] <= '0;
      mask_q <= '0;
      page_q <= '0;
    end else begin
      if (clear_i || commit_i) mask_q <= '0;
      if (wr_en_i) begin
        pbuf_q[wr_addr_i[PAGE_AW-1:0]] <= wr_data_i;
        mask_q[wr_addr_i[PAGE_AW-1:0]] <= 1'b1;
        page_q <= wr_addr_i[MEM_AW-1:PAGE_AW];
      end
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];
  assign pending_o = |mask_q;
endmodule

// File: rtl/i2c_eep_slave.sv
module i2c_eep_slave
  import i2c_eep_pkg::*;
#(
  parameter int         MEM_AW      = 8,
  parameter int         PAGE_AW     = 4,
  parameter logic [2:0] ADDR_SEL    = 3'b000,
  parameter int         PROG_CYCLES = 500,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o
);
  localparam int BUSY_W = $clog2(PROG_CYCLES + 1);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  i2c_eep_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  eep_state_e        state_q, ack_next_q;
  logic [2:0]        bit_cnt_q;
  logic              byte_rdy_q, mack_q, sda_oe_q;
  logic [7:0]        sh_q, tx_q, rd_data;
  logic [MEM_AW-1:0] addr_q;
  logic [BUSY_W-1:0] busy_cnt_q;
  logic              busy, commit, pending, proc, dev_match, st_clear, st_wr;

  assign busy      = busy_cnt_q != '0;
  assign commit    = stop_det & pending;
  assign proc      = scl_fall & byte_rdy_q & ~start_det & ~stop_det;
  assign dev_match = sh_q[7:1] == {DEV_TYPE, ADDR_SEL};
  assign st_clear  = proc & (state_q == ST_WADDR);
  assign st_wr     = proc & (state_q == ST_WDATA);

  i2c_eep_store #(.MEM_AW(MEM_AW), .PAGE_AW(PAGE_AW)) u_store (
    .clk_i, .rst_ni,
    .rd_addr_i(addr_q), .rd_data_o(rd_data),
    .clear_i(st_clear), .wr_en_i(st_wr), .wr_addr_i(addr_q), .wr_data_i(sh_q),
    .commit_i(commit), .pending_o(pending)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_cnt_q <= '0;
    else if (commit) busy_cnt_q <= BUSY_W'(PROG_CYCLES);
    else if (busy) busy_cnt_q <= busy_cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      ack_next_q <= ST_IDLE;
      bit_cnt_q  <= '0;
      byte_rdy_q <= 1'b0;
      mack_q     <= 1'b0;
      sda_oe_q   <= 1'b0;
      sh_q       <= '0;
      tx_q       <= '0;
      addr_q     <= '0;
    end else if (start_det) begin
      state_q    <= ST_DEV;
      bit_cnt_q  <= '0;
      byte_rdy_q <= 1'b0;
      sda_oe_q   <= 1'b0;
    end else if (stop_det) begin
      state_q    <= ST_IDLE;
      byte_rdy_q <= 1'b0;
      sda_oe_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_DEV, ST_WADDR, ST_WDATA: begin
          if (scl_rise) begin
            sh_q      <= {sh_q[6:0], sda_s};
            bit_cnt_q <= bit_cnt_q + 3'd1;
            if (bit_cnt_q == 3'd7) byte_rdy_q <= 1'b1;
          end
          if (proc) begin
            byte_rdy_q <= 1'b0;
            state_q    <= ST_ACK;
            sda_oe_q   <= 1'b1;
            if (state_q == ST_DEV) begin
              ack_next_q <= sh_q[0] ? ST_TX : ST_WADDR;
              if (!dev_match || busy) begin
                state_q  <= ST_SKIP;
                sda_oe_q <= 1'b0;
              end
            end else if (state_q == ST_WADDR) begin
              addr_q     <= sh_q[MEM_AW-1:0];
              ack_next_q <= ST_WDATA;
            end else begin
              addr_q[PAGE_AW-1:0] <= addr_q[PAGE_AW-1:0] + 1'b1;
              ack_next_q          <= ST_WDATA;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            bit_cnt_q <= '0;
            if (ack_next_q == ST_TX) begin
              tx_q     <= rd_data;
              sda_oe_q <= ~rd_data[7];
              addr_q   <= addr_q + 1'b1;
              state_q  <= ST_TX;
            end else begin
              sda_oe_q <= 1'b0;
              state_q  <= ack_next_q;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bit_cnt_q == 3'd7) begin
              sda_oe_q  <= 1'b0;
              mack_q    <= 1'b0;
              bit_cnt_q <= '0;
              state_q   <= ST_RACK;
            end else begin
              tx_q      <= {tx_q[6:0], 1'b0};
              sda_oe_q  <= ~tx_q[6];
              bit_cnt_q <= bit_cnt_q + 3'd1;
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) mack_q <= ~sda_s;
          if (scl_fall) begin
            if (mack_q) begin
              tx_q      <= rd_data;
              sda_oe_q  <= ~rd_data[7];
              addr_q    <= addr_q + 1'b1;
              bit_cnt_q <= '0;
              state_q   <= ST_TX;
            end else begin
              state_q <= ST_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe_o = sda_oe_q;
endmodule

// File: rtl/i2c_eep_slave_chk.sv
module i2c_eep_slave_chk
  import i2c_eep_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       scl_s,
  input logic       sda_oe_o,
  input logic       busy,
  input logic       start_det,
  input logic       stop_det,
  input logic       commit,
  input eep_state_e state_q
);
  assert_start_restarts_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det |=> state_q == ST_DEV);

  assert_stop_releases_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> (!sda_oe_o && state_q == ST_IDLE));

  assert_drive_in_low_phase_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !$past(scl_s));

  assert_commit_starts_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |=> busy);

  assert_silent_when_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> !sda_oe_o);

  assert_idle_released_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_IDLE |-> !sda_oe_o);
endmodule

bind i2c_eep_slave i2c_eep_slave_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_s(scl_s), .sda_oe_o(sda_oe_o),
  .busy(busy), .start_det(start_det), .stop_det(stop_det),
  .commit(commit), .state_q(state_q)
);

// File: tb/test_i2c_eep_slave.sv
module test_i2c_eep_slave;
  localparam int         PROG = 300;
  localparam logic [2:0] SEL  = 3'b101;
  localparam int         T    = 6;
  localparam logic [7:0] DEV_W = {4'b1010, SEL, 1'b0};
  localparam logic [7:0] DEV_R = {4'b1010, SEL, 1'b1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_oe;
  logic sda_line;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done = 1'b0;

  always #5 clk = ~clk;
  assign sda_line = m_sda & ~sda_oe;

  i2c_eep_slave #(.ADDR_SEL(SEL), .PROG_CYCLES(PROG)) i_i2c_eep_slave (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_oe_o(sda_oe)
  );

  function automatic logic [7:0] pat(int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hold(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; hold(T);
    m_scl = 1'b1; hold(T);
    m_sda = 1'b0; hold(T);
    m_scl = 1'b0; hold(T);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; hold(T);
    m_scl = 1'b1; hold(T);
    m_sda = 1'b1; hold(T);
  endtask

  task automatic wb(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; hold(T);
      m_scl = 1'b1; hold(T);
      m_scl = 1'b0;
    end
    m_sda = 1'b1; hold(T);
    m_scl = 1'b1; hold(T / 2);
    ack = !sda_line;
    hold(T / 2);
    m_scl = 1'b0; hold(1);
  endtask

  task automatic rb(input bit nack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hold(T);
      m_scl = 1'b1; hold(T / 2);
      b[i] = sda_line;
      hold(T / 2);
      m_scl = 1'b0;
    end
    m_sda = nack; hold(T);
    m_scl = 1'b1; hold(T);
    m_scl = 1'b0;
    m_sda = 1'b1; hold(1);
  endtask

  // R3: pull-down may only change while the bus clock is low
  logic oe_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n && sda_oe !== oe_prev) check(!m_scl, "R3 oe edge during scl high", m_scl, 0);
    oe_prev <= sda_oe;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: got %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    bit         ack;
    logic [7:0] d;
    hold(5);
    rst_n = 1'b1;
    hold(5);
    check(sda_oe == 1'b0, "R11 released after reset", sda_oe, 0);

    // R11 / R9: current-address read right after reset
    bus_start();
    wb(DEV_R, ack);
    check(ack, "R4 read address ack", ack, 1);
    rb(1'b1, d);
    check(d == 8'h00, "R11 array zero at reset", d, 0);
    bus_stop();

    // R4: sweep all device addresses
    for (int a = 0; a < 128; a++) begin
      bus_start();
      wb(8'(a << 1), ack);
      check(ack == (a == int'(DEV_W >> 1)), "R4 address match", ack, a == int'(DEV_W >> 1));
      if (a == 8'h50) begin
        wb(8'h00, ack);
        check(!ack, "R4 unmatched stays silent", ack, 0);
      end
      bus_stop();
    end

    // R5 / R7 / R8: fill every page
    for (int p = 0; p < 16; p++) begin
      bus_start();
      wb(DEV_W, ack);
      check(ack, "R5 device ack", ack, 1);
      wb(8'(p * 16), ack);
      check(ack, "R5 word address ack", ack, 1);
      for (int o = 0; o < 16; o++) begin
        wb(pat(p * 16 + o), ack);
        check(ack, "R5 data ack", ack, 1);
      end
      bus_stop();
      if (p == 0) begin
        bus_start();
        wb(DEV_W, ack);
        check(!ack, "R8 no ack while busy", ack, 0);
        bus_stop();
      end
      hold(PROG);
      if (p == 1) begin
        bus_start();
        wb(DEV_W, ack);
        check(ack, "R7 busy interval ends", ack, 1);
        bus_stop();
      end
    end

    // R9 / R10: random read across the wrap, then master nack
    bus_start();
    wb(DEV_W, ack);
    wb(8'h00, ack);
    bus_start();
    wb(DEV_R, ack);
    check(ack, "R1 repeated start read ack", ack, 1);
    for (int k = 0; k < 258; k++) begin
      rb(k == 257, d);
      check(d == pat(k % 256), "R9 sequential read", d, pat(k % 256));
    end
    rb(1'b1, d);
    check(d == 8'hFF, "R10 silent after nack", d, 8'hFF);
    bus_stop();

    // R6: 20 bytes from offset 5 of page 3
    bus_start();
    wb(DEV_W, ack);
    wb(8'h35, ack);
    for (int k = 0; k < 20; k++) begin
      wb(8'(8'hC0 + k), ack);
      check(ack, "R6 overflow byte ack", ack, 1);
    end
    bus_stop();
    hold(PROG + 20);
    bus_start();
    wb(DEV_W, ack);
    wb(8'h30, ack);
    bus_start();
    wb(DEV_R, ack);
    for (int o = 0; o < 17; o++) begin
      int         k0;
      logic [7:0] exp;
      k0  = (o - 5 + 16) % 16;
      exp = (o == 16) ? pat(8'h40) : 8'(8'hC0 + ((k0 + 16 < 20) ? k0 + 16 : k0));
      rb(o == 16, d);
      check(d == exp, "R6 page wrap retention", d, exp);
    end
    bus_stop();

    // R7: address-only write starts no busy interval
    bus_start();
    wb(DEV_W, ack);
    wb(8'h80, ack);
    bus_stop();
    bus_start();
    wb(DEV_W, ack);
    check(ack, "R7 no busy without data", ack, 1);
    wb(8'h80, ack);
    bus_start();
    wb(DEV_R, ack);
    rb(1'b1, d);
    check(d == pat(8'h80), "R7 memory unchanged", d, pat(8'h80));
    bus_stop();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule